// File: doc/BRIEF.md
# Shared Bus Ownership Arbiter

This block decides which of four masters owns a shared system bus. The masters are a memory refresh engine, two DMA channels and an external bus master. Each master raises its own request line and receives its own acknowledge line. Before any master is acknowledged, the arbiter borrows the bus from the processor core. It raises a hold request and waits for the core to answer with hold acknowledge. Only then does it grant the bus to one winner.

Refresh always wins. The other three masters form a circular ring: DMA channel 0, then DMA channel 1, then the external master, then back to channel 0. Where the ring starts is chosen by a mode input:
- In fixed mode the order is channel 0, channel 1, external master.
- In programmed mode software names the ring member that ranks lowest. The member after it in the ring ranks highest.
- In rotating mode each ring member that wins a grant becomes the lowest for the decisions that follow.

A grant lasts as long as the owner holds its request. When the owner drops its request, the arbiter either re-arbitrates with hold kept up, or hands the bus back to the core.

Top module: `busown_arbiter`

## Requirements
- R1: While idle, any request raises `hold_req`. No acknowledge is raised in a cycle unless `hold_ack` was high in the cycle before.
- R2: If `refresh_req` is high at a decision, `refresh_ack` is the acknowledge given, in every mode.
- R3: With `prio_mode` = 0 or 3 (fixed), the ring members rank channel 0 first, then channel 1, then the external master.
- R4: With `prio_mode` = 1 (programmed), `low_sel` names the lowest ring member: 0 for channel 0, 1 for channel 1, 2 or 3 for the external master. The next member in the ring ranks highest and the one after it ranks middle.
- R5: With `prio_mode` = 2 (rotating), a ring member that is granted while in this mode becomes the lowest. The lowest member is the external master after reset. Refresh grants, and grants in other modes, leave this lowest member unchanged.
- R6: At most one acknowledge is high in any cycle.
- R7: An acknowledge stays high for as long as its request stays high, even if refresh asks meanwhile.
- R8: The cycle after the owner drops its request, all acknowledges are low. `hold_req` then stays high if other requests are pending, and goes low if none are.
- R9: Once `hold_req` has dropped, it is not raised again until `hold_ack` has been seen low.
- R10: Changing `prio_mode` or `low_sel` during a grant does not disturb the current owner. The new setting is used at the next decision.
- R11: After reset, all acknowledges and `hold_req` are low, and the rotating order starts with the external master lowest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refresh_req | input | 1 | Refresh engine asks for the bus |
| dma0_req | input | 1 | DMA channel 0 asks for the bus |
| dma1_req | input | 1 | DMA channel 1 asks for the bus |
| xmst_req | input | 1 | External bus master asks for the bus |
| prio_mode | input | 2 | 0/3 fixed, 1 programmed lowest, 2 rotating |
| low_sel | input | 2 | Lowest ring member in programmed mode |
| hold_ack | input | 1 | Core has released the bus |
| hold_req | output | 1 | Asks the core to release the bus |
| refresh_ack | output | 1 | Bus granted to refresh |
| dma0_ack | output | 1 | Bus granted to DMA channel 0 |
| dma1_ack | output | 1 | Bus granted to DMA channel 1 |
| xmst_ack | output | 1 | Bus granted to the external master |

## Verification
The assertions rely on two assumptions about the inputs:
- The core keeps `hold_ack` high while `hold_req` is high, and lowers it only after `hold_req` has dropped.
- A master does not re-raise its request in the same cycle it is released.

The bench models the core as a two-cycle echo of `hold_req`, which meets the first assumption. Its random stimulus only adds requests for masters that are not the current owner, and it changes mode or lowest selection only at falling edges. The expected winner therefore always comes from requests and settings that were steady at the deciding edge.

// File: rtl/arb_pkg.sv
// Package: shared encodings for the bus ownership arbiter.
// Assumes a three-member ring below an always-first refresh requester.
package arb_pkg;
    localparam int RING_N = 3;
    localparam int RING_W = $clog2(RING_N);
    localparam int REQ_N  = RING_N + 1;

    typedef enum logic [1:0] {
        MODE_FIXED  = 2'd0,
        MODE_LOWSEL = 2'd1,
        MODE_ROTATE = 2'd2,
        MODE_FIXED2 = 2'd3
    } prio_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ASK  = 2'd1,
        ST_OWN  = 2'd2,
        ST_DROP = 2'd3
    } arb_state_e;
endpackage

// File: rtl/arb_ring_pick.sv
// Module: arb_ring_pick
// Picks one ring member, starting just after the member named lowest and
// walking circularly. Purely combinational. Assumes lowest < N.
module arb_ring_pick #(
    parameter int N = 3,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] lowest,
    output logic [N-1:0] grant
);
    // Walk the ring from the member after `lowest` and take the first request.
    always_comb begin
        logic found;
        grant = '0;
        found = 1'b0;
        for (int s = 0; s < N; s++) begin
            int idx;
            idx = (int'(lowest) + 1 + s) % N;
            if (!found && req[idx]) begin
                grant[idx] = 1'b1;
                found      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/arb_rot_ptr.sv
// Module: arb_rot_ptr
// Holds the rotating-mode lowest ring member. Reset places member N-1 lowest.
// Assumes upd is a single-cycle pulse at a ring grant.
module arb_rot_ptr #(
    parameter int N = 3,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [W-1:0] win_idx,
    output logic [W-1:0] low_idx
);
    // Load the newly granted member as lowest.
    always_ff @(posedge clk) begin
        if (!rst_n) low_idx <= W'(N - 1);
        else if (upd) low_idx <= win_idx;
    end

    // R5: the pointer moves only on a rotating-mode ring grant
    a_r5_ptr_moves_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(low_idx));
    // R5: the pointer always names a ring member
    a_r5_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(low_idx) < N);
endmodule

// File: rtl/arb_handshake.sv
// Module: arb_handshake
// Hold handshake with the core and grant ownership tracking. Grants the
// one-hot `pick` once hold_ack is seen, keeps the owner until its request
// drops, then re-arbitrates or returns the bus. Assumes the core keeps
// hold_ack high while hold_req is high.
module arb_handshake
    import arb_pkg::*;
#(
    parameter int NREQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req,
    input  logic [NREQ-1:0] pick,
    input  logic            hold_ack,
    output logic            hold_req,
    output logic            grant_evt,
    output logic [NREQ-1:0] ack
);
    arb_state_e state;
    logic       any_req;
    logic       owner_on;
    logic       others_on;

    assign any_req   = |req;
    assign owner_on  = |(ack & req);
    assign others_on = |(req & ~ack);
    assign hold_req  = (state == ST_ASK) || (state == ST_OWN);
    assign grant_evt = (state == ST_ASK) && hold_ack && any_req;

    // Sequence idle, ask, own and drop, and register the acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ack   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (any_req) state <= ST_ASK;
                ST_ASK: begin
                    if (!any_req) state <= ST_DROP;
                    else if (hold_ack) begin
                        ack   <= pick;
                        state <= ST_OWN;
                    end
                end
                ST_OWN: begin
                    if (!owner_on) begin
                        ack   <= '0;
                        state <= others_on ? ST_ASK : ST_DROP;
                    end
                end
                default: if (!hold_ack) state <= ST_IDLE;
            endcase
        end
    end

    // R1: an acknowledge appears only after the core released the bus
    a_r1_ack_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|ack) |-> $past(hold_ack));
    // R6: never two owners
    a_r6_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack));
    // R7: the owner keeps the bus while it still asks
    a_r7_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack & req)) |=> ack == $past(ack));
    // R8: a released owner loses its acknowledge next cycle
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack & ~req)) |=> ack == '0);
    // R9: hold is re-raised only after the core dropped hold_ack
    a_r9_rehold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_req) |-> !$past(hold_ack));
endmodule

// File: rtl/busown_arbiter.sv
// Module: busown_arbiter
// Top of the shared bus ownership arbiter: refresh above a three-member
// ring whose order is fixed, programmed by its lowest member, or rotated
// after each ring grant. Assumes settings inputs are synchronous to clk.
module busown_arbiter
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       refresh_req,
    input  logic       dma0_req,
    input  logic       dma1_req,
    input  logic       xmst_req,
    input  logic [1:0] prio_mode,
    input  logic [1:0] low_sel,
    input  logic       hold_ack,
    output logic       hold_req,
    output logic       refresh_ack,
    output logic       dma0_ack,
    output logic       dma1_ack,
    output logic       xmst_ack
);
    logic [RING_N-1:0] ring_req;
    logic [RING_N-1:0] ring_grant;
    logic [RING_W-1:0] low_eff;
    logic [RING_W-1:0] rot_low;
    logic [RING_W-1:0] win_idx;
    logic [REQ_N-1:0]  all_req;
    logic [REQ_N-1:0]  pick;
    logic [REQ_N-1:0]  ack;
    logic              grant_evt;
    logic              rot_upd;
    prio_mode_e        mode;

    assign mode     = prio_mode_e'(prio_mode);
    assign ring_req = {xmst_req, dma1_req, dma0_req};
    assign all_req  = {ring_req, refresh_req};

    // Choose the lowest ring member for the current mode.
    always_comb begin
        case (mode)
            MODE_LOWSEL: low_eff = (int'(low_sel) >= RING_N) ? RING_W'(RING_N - 1)
                                                             : RING_W'(low_sel);
            MODE_ROTATE: low_eff = rot_low;
            default:     low_eff = RING_W'(RING_N - 1);
        endcase
    end

    arb_ring_pick #(.N(RING_N), .W(RING_W)) u_pick (
        .req    (ring_req),
        .lowest (low_eff),
        .grant  (ring_grant)
    );

    // Refresh overrides the ring choice.
    assign pick = refresh_req ? REQ_N'(1) : {ring_grant, 1'b0};

    // Encode the ring winner index for the rotation pointer.
    always_comb begin
        win_idx = '0;
        for (int i = 0; i < RING_N; i++)
            if (ring_grant[i]) win_idx = RING_W'(i);
    end

    assign rot_upd = grant_evt && (mode == MODE_ROTATE) && !refresh_req;

    arb_rot_ptr #(.N(RING_N), .W(RING_W)) u_rot (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (rot_upd),
        .win_idx (win_idx),
        .low_idx (rot_low)
    );

    arb_handshake #(.NREQ(REQ_N)) u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (all_req),
        .pick      (pick),
        .hold_ack  (hold_ack),
        .hold_req  (hold_req),
        .grant_evt (grant_evt),
        .ack       (ack)
    );

    assign refresh_ack = ack[0];
    assign dma0_ack    = ack[1];
    assign dma1_ack    = ack[2];
    assign xmst_ack    = ack[3];

    // R2: a decision taken with refresh pending grants refresh
    a_r2_refresh_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_evt && refresh_req) |=> refresh_ack);
    // R3: fixed mode with channel 0 pending never grants another ring member
    a_r3_fixed_ch0_first: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_evt && !refresh_req && dma0_req &&
         (mode == MODE_FIXED || mode == MODE_FIXED2)) |=> dma0_ack);
    // R4: programmed mode with external master lowest behaves as fixed order
    a_r4_lowsel_ch0_first: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_evt && !refresh_req && dma0_req && mode == MODE_LOWSEL &&
         low_sel[1]) |=> dma0_ack);
    // R11: reset leaves no owner and no hold
    a_r11_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (ack == '0) && !hold_req);
endmodule

// File: tb/busown_arbiter_test.sv
module busown_arbiter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reqv = 4'b0;      // bit0 refresh, bit1 dma0, bit2 dma1, bit3 external
    logic [1:0] mode = 2'd0;
    logic [1:0] lsel = 2'd0;
    logic       hold_ack = 1'b0;
    logic       hak_d = 1'b0;
    logic       hold_req;
    logic       refresh_ack, dma0_ack, dma1_ack, xmst_ack;
    logic [3:0] acks;
    int         checks = 0;
    int         fails = 0;
    int         brot = 2;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    busown_arbiter uut (
        .clk(clk), .rst_n(rst_n),
        .refresh_req(reqv[0]), .dma0_req(reqv[1]), .dma1_req(reqv[2]), .xmst_req(reqv[3]),
        .prio_mode(mode), .low_sel(lsel), .hold_ack(hold_ack), .hold_req(hold_req),
        .refresh_ack(refresh_ack), .dma0_ack(dma0_ack), .dma1_ack(dma1_ack), .xmst_ack(xmst_ack)
    );
    assign acks = {xmst_ack, dma1_ack, dma0_ack, refresh_ack};

    // Core model: echoes hold_req two cycles later.
    always @(posedge clk) begin
        if (!rst_n) begin
            hak_d    <= 1'b0;
            hold_ack <= 1'b0;
        end else begin
            hak_d    <= hold_req;
            hold_ack <= hak_d;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_pick(input logic [3:0] r, input logic [1:0] m,
                                            input logic [1:0] ls, input int rot);
        int low;
        if (r[0]) return 4'b0001;
        low = (m == 2'd1) ? ((ls == 2'd3) ? 2 : int'(ls)) : (m == 2'd2) ? rot : 2;
        for (int s = 0; s < 3; s++) begin
            int idx;
            idx = (low + 1 + s) % 3;
            if (r[idx+1]) return 4'b0001 << (idx + 1);
        end
        return 4'b0000;
    endfunction

    // Continuous monitors for R6, R1 and R9.
    logic [3:0] p_acks = 4'b0;
    logic       p_hak = 1'b0;
    logic       p_hreq = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk($countones(acks) <= 1, "R6 single ack", acks, 4'b0);
            if (acks != 4'b0 && p_acks == 4'b0)
                chk(p_hak, "R1 ack after hold_ack", {3'b0, p_hak}, 4'b0001);
            if (hold_req && !p_hreq)
                chk(!p_hak, "R9 rehold after hold_ack low", {3'b0, p_hak}, 4'b0000);
        end
        p_acks = acks;
        p_hak  = hold_ack;
        p_hreq = hold_req;
    end

    task automatic wait_grant(output logic [3:0] g);
        logic [3:0] e;
        int n;
        e = exp_pick(reqv, mode, lsel, brot);
        n = 0;
        while (acks == 4'b0 && n < 30) begin
            @(negedge clk);
            n++;
        end
        g = acks;
        chk(g == e, "R2 R3 R4 R5 winner", g, e);
        if (mode == 2'd2 && !g[0]) begin
            for (int i = 0; i < 3; i++) if (g[i+1]) brot = i;
        end
    endtask

    task automatic release_owner(input logic [3:0] g);
        reqv = reqv & ~g;
        @(negedge clk);
        chk(acks == 4'b0, "R8 ack drops", acks, 4'b0);
        chk(hold_req == (reqv != 4'b0), "R8 hold after release", {3'b0, hold_req},
            {3'b0, reqv != 4'b0});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] g;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(acks == 4'b0 && !hold_req, "R11 reset state", {hold_req, acks[2:0]}, 4'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: hold raised first, no ack before hold_ack
        reqv = 4'b0010;
        @(negedge clk);
        chk(hold_req && acks == 4'b0, "R1 hold before ack", {hold_req, acks[2:0]}, 4'b1000);
        wait_grant(g);
        release_owner(g);
        repeat (4) @(negedge clk);

        // R2 and R3: all ask in fixed mode
        reqv = 4'b1111;
        for (int k = 0; k < 4; k++) begin
            wait_grant(g);
            release_owner(g);
        end
        repeat (4) @(negedge clk);

        // R7: refresh does not preempt channel 1
        reqv = 4'b0100;
        wait_grant(g);
        reqv[0] = 1'b1;
        repeat (5) @(negedge clk);
        chk(acks == 4'b0100, "R7 no preemption", acks, 4'b0100);
        // R10: settings change during the grant leaves the owner alone
        mode = 2'd1; lsel = 2'd0; reqv[1] = 1'b1; reqv[3] = 1'b1;
        @(negedge clk);
        chk(acks == 4'b0100, "R10 owner kept on mode change", acks, 4'b0100);
        release_owner(g);
        wait_grant(g);      // refresh
        release_owner(g);
        reqv[2] = 1'b1;
        wait_grant(g);      // R4: channel 0 lowest, so channel 1 wins
        chk(g == 4'b0100, "R4 follower of lowest wins", g, 4'b0100);
        release_owner(g);
        lsel = 2'd3;
        wait_grant(g);      // R4: 3 means external lowest
        chk(g == 4'b0010, "R4 code 3 as external lowest", g, 4'b0010);
        release_owner(g);
        wait_grant(g);
        release_owner(g);
        repeat (4) @(negedge clk);

        // R5: rotation starts with the external master lowest
        mode = 2'd2;
        reqv = 4'b1110;
        wait_grant(g);
        chk(g == 4'b0010, "R5 rotate start", g, 4'b0010);
        release_owner(g);
        reqv[1] = 1'b1;
        wait_grant(g);
        chk(g == 4'b0100, "R5 winner moved lowest", g, 4'b0100);
        release_owner(g);

        // Random mix of requests and settings.
        for (int it = 0; it < 400; it++) begin
            logic [3:0] add;
            add = 4'($urandom());
            if ($urandom_range(0, 3) == 0) begin
                mode = 2'($urandom());
                lsel = 2'($urandom());
            end
            reqv = reqv | add;
            if (reqv == 4'b0) begin
                @(negedge clk);
                continue;
            end
            wait_grant(g);
            repeat ($urandom_range(0, 3)) @(negedge clk);
            reqv = reqv | (4'($urandom()) & ~g);
            if ($urandom_range(0, 1) == 1) begin
                mode = 2'($urandom());
                lsel = 2'($urandom());
                @(negedge clk);
                chk(acks == g, "R10 owner kept", acks, g);
            end
            release_owner(g);
            if ($urandom_range(0, 4) == 0) begin
                reqv = 4'b0;
                repeat (3) @(negedge clk);
            end
        end

        // Drain any leftover requests.
        while (reqv != 4'b0) begin
            wait_grant(g);
            release_owner(g);
        end
        repeat (5) @(negedge clk);
        chk(!hold_req && acks == 4'b0, "R8 idle at end", {hold_req, acks[2:0]}, 4'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule